// File: doc/BRIEF.md
# Four-Beat Wide Search Key Assembler

This block sits on the host command bus of a ternary search engine. A 288-bit search key does not fit on the 72-bit data bus, so the host sends it as four consecutive search beats. Each beat carries one quarter of the key. Each beat also carries command fields, and those fields sit in different command bits depending on the beat. The assembler follows the beats in order. It captures each key word together with the fields that belong to that beat. After the fourth beat it presents the whole key and its fields to the match logic, along with a one-cycle ready pulse.

A width flag on command bit 2 tells the wide sequence apart from other traffic. The flag must be set on the first beat and clear on the third. Two kinds of protocol error are handled. If the sequence breaks before the last beat, the assembler abandons it and raises an error. If the flag is set where it should be clear, the assembler raises an error and restarts the collection from that beat.

Top module: `wide_key_asm`

## Requirements
- R1: A beat is counted only in a cycle where `cmd_vld` is 1 and `cmd[1:0]` is 2'b10. Any other opcode, or `cmd_vld` at 0, is not a beat.
- R2: From idle, a beat with `cmd[2]`=1 starts a wide search and counts as the first word. A beat in idle with `cmd[2]`=0 is ignored: it raises neither `srch_rdy` nor `proto_err`.
- R3: The data bus is placed into `key` as follows: first beat into bits [287:216], second beat into [215:144], third beat into [143:72], fourth beat into [71:0].
- R4: `mpair_hi` is {`cmd[10]`,`cmd[5:3]`} of the first beat. `mpair_lo` is the same field of the third beat.
- R5: `addr_top` is `cmd[8:6]` of the third beat. `rslt_sel` is `cmd[8:6]` of the fourth beat.
- R6: The following command bits are ignored: `cmd[9]` and `cmd[8:6]` of the first beat, `cmd[10:2]` of the second beat, and `cmd[10:9]` and `cmd[5:2]` of the fourth beat. Changing them leaves every output unchanged.
- R7: `srch_rdy` is high for exactly the one cycle after the clock edge that takes the fourth beat. The key and field outputs update at that same edge and hold until the next completed search.
- R8: If a non-beat cycle arrives after the first, second or third beat, `proto_err` is high for the next cycle, the partial search is dropped, and the assembler returns to idle.
- R9: A third beat with `cmd[2]`=1 raises `proto_err` for one cycle. That beat is then taken as a new first beat, including its data word and its `mpair_hi` field.
- R10: While `rst_n` is low, all outputs are 0 and the assembler is idle.
- R11: A new first beat in the cycle right after a fourth beat is accepted with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command valid |
| cmd | input | 11 | Command bus: opcode, width flag and per-beat fields |
| dq | input | 72 | Key data word for the current beat |
| key | output | 288 | Assembled search key |
| mpair_hi | output | 4 | Mask-pair index for key bits [287:144] |
| mpair_lo | output | 4 | Mask-pair index for key bits [143:0] |
| rslt_sel | output | 3 | Result register that will hold the match address and hit flag |
| addr_top | output | 3 | Upper SRAM address bits [23:21] driven on a hit |
| srch_rdy | output | 1 | One-cycle pulse: a complete key is on the outputs |
| proto_err | output | 1 | One-cycle pulse: a protocol error was seen |

## Verification
Every result is one register deep. `srch_rdy` and the assembled fields appear at the edge that takes the fourth beat. `proto_err` appears at the edge that takes the offending cycle. The bench drives each beat just after a rising edge and checks the outputs just after the next rising edge, so every check reads the result of exactly one beat. For the hold checks, the bench runs extra idle cycles and confirms that the fields stay the same while `srch_rdy` is back at 0.

// File: rtl/wide_key_asm.sv
module wide_key_asm #(
  parameter int BEAT_W = 72,
  parameter int BEATS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_vld,
  input  logic [10:0]               cmd,
  input  logic [BEAT_W-1:0]         dq,
  output logic [BEAT_W*BEATS-1:0]   key,
  output logic [3:0]                mpair_hi,
  output logic [3:0]                mpair_lo,
  output logic [2:0]                rslt_sel,
  output logic [2:0]                addr_top,
  output logic                      srch_rdy,
  output logic                      proto_err
);
  localparam int KEY_W = BEAT_W * BEATS;
  localparam logic [1:0] S_IDLE = 2'd0, S_A = 2'd1, S_B = 2'd2, S_C = 2'd3;

  logic [1:0]            state;
  logic [KEY_W-1:BEAT_W] stage;
  logic [3:0]            hi_q, lo_q;
  logic [2:0]            addr_q;

  wire       beat = cmd_vld && (cmd[1:0] == 2'b10);
  wire       wide = cmd[2];
  wire [3:0] idx  = {cmd[10], cmd[5:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stage     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      addr_q    <= '0;
      key       <= '0;
      mpair_hi  <= '0;
      mpair_lo  <= '0;
      rslt_sel  <= '0;
      addr_top  <= '0;
      srch_rdy  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      srch_rdy  <= 1'b0;
      proto_err <= 1'b0;
      case (state)
        S_IDLE: if (beat && wide) begin
          stage[KEY_W-1 -: BEAT_W] <= dq;
          hi_q  <= idx;
          state <= S_A;
        end
        S_A: if (beat) begin
          stage[KEY_W-BEAT_W-1 -: BEAT_W] <= dq;
          state <= S_B;
        end else begin
          proto_err <= 1'b1;
          state     <= S_IDLE;
        end
        S_B: if (!beat) begin
          proto_err <= 1'b1;
          state     <= S_IDLE;
        end else if (wide) begin
          proto_err <= 1'b1;
          stage[KEY_W-1 -: BEAT_W] <= dq;
          hi_q  <= idx;
          state <= S_A;
        end else begin
          stage[KEY_W-2*BEAT_W-1 -: BEAT_W] <= dq;
          lo_q   <= idx;
          addr_q <= cmd[8:6];
          state  <= S_C;
        end
        S_C: if (beat) begin
          key      <= {stage, dq};
          mpair_hi <= hi_q;
          mpair_lo <= lo_q;
          addr_top <= addr_q;
          rslt_sel <= cmd[8:6];
          srch_rdy <= 1'b1;
          state    <= S_IDLE;
        end else begin
          proto_err <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wide_key_asm_chk.sv
module wide_key_asm_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_vld,
  input logic [10:0]  cmd,
  input logic [1:0]   st,
  input logic [287:0] key,
  input logic [3:0]   mpair_hi,
  input logic [3:0]   mpair_lo,
  input logic [2:0]   rslt_sel,
  input logic [2:0]   addr_top,
  input logic         srch_rdy,
  input logic         proto_err
);
  wire is_beat = cmd_vld && (cmd[1:0] == 2'b10);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    srch_rdy |=> !srch_rdy);

  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_rdy |-> $stable({key, mpair_hi, mpair_lo, rslt_sel, addr_top}));

  a_r1_rdy_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    srch_rdy |-> $past(is_beat));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 2'd0) |-> (!srch_rdy && !proto_err));

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != 2'd0 && !$past(is_beat)) |-> (proto_err && st == 2'd0));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 2'd2 && $past(is_beat && cmd[2])) |-> (proto_err && st == 2'd1));
endmodule

bind wide_key_asm wide_key_asm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .st(state),
  .key(key), .mpair_hi(mpair_hi), .mpair_lo(mpair_lo), .rslt_sel(rslt_sel),
  .addr_top(addr_top), .srch_rdy(srch_rdy), .proto_err(proto_err)
);

// File: tb/sim_wide_key_asm.sv
module sim_wide_key_asm;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_vld = 1'b0;
  logic [10:0]  cmd = '0;
  logic [71:0]  dq = '0;
  logic [287:0] key;
  logic [3:0]   mpair_hi, mpair_lo;
  logic [2:0]   rslt_sel, addr_top;
  logic         srch_rdy, proto_err;
  int           n_chk = 0;
  int           n_bad = 0;

  always #10 clk = ~clk;

  wide_key_asm u0 (.clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .dq(dq),
    .key(key), .mpair_hi(mpair_hi), .mpair_lo(mpair_lo), .rslt_sel(rslt_sel),
    .addr_top(addr_top), .srch_rdy(srch_rdy), .proto_err(proto_err));

  // {vld, cmd[10:0], data tag, exp rdy, exp err}
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 11'h000, 8'h00, 1'b0, 1'b0},
    {1'b1, 11'h006, 8'h11, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h22, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h33, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h44, 1'b1, 1'b0},
    {1'b1, 11'h002, 8'h55, 1'b0, 1'b0},
    {1'b1, 11'h006, 8'h66, 1'b0, 1'b0},
    {1'b0, 11'h002, 8'h77, 1'b0, 1'b1},
    {1'b1, 11'h002, 8'h88, 1'b0, 1'b0},
    {1'b1, 11'h006, 8'h99, 1'b0, 1'b0},
    {1'b1, 11'h003, 8'hAA, 1'b0, 1'b1},
    {1'b1, 11'h006, 8'hBB, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'hCC, 1'b0, 1'b0},
    {1'b1, 11'h006, 8'hDD, 1'b0, 1'b1},
    {1'b1, 11'h002, 8'hEE, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h12, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h34, 1'b1, 1'b0},
    {1'b1, 11'h006, 8'h56, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h78, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'h9A, 1'b0, 1'b0},
    {1'b1, 11'h002, 8'hBC, 1'b1, 1'b0},
    {1'b0, 11'h000, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [287:0] act, input logic [287:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic [10:0] c, input logic [71:0] d);
    cmd_vld = v; cmd = c; dq = d;
    @(posedge clk); #2;
  endtask

  function automatic logic [10:0] cmd_a(input logic [3:0] h, input logic [3:0] junk);
    return {h[3], junk[3], junk[2:0], h[2:0], 1'b1, 2'b10};
  endfunction
  function automatic logic [10:0] cmd_c(input logic [3:0] l, input logic [2:0] a, input logic j, input logic w);
    return {l[3], j, a, l[2:0], w, 2'b10};
  endfunction
  function automatic logic [10:0] cmd_d(input logic [2:0] r, input logic [5:0] junk);
    return {junk[5:4], r, junk[3:0], 2'b10};
  endfunction

  task automatic full_search(input logic [71:0] w0, w1, w2, w3, input logic [3:0] h, l,
                             input logic [2:0] a, r, input logic [8:0] junk);
    beat(1'b1, cmd_a(h, junk[3:0]), w0);
    beat(1'b1, {junk, 2'b10}, w1);
    beat(1'b1, cmd_c(l, a, junk[4], 1'b0), w2);
    beat(1'b1, cmd_d(r, junk[8:3]), w3);
    check("R7 rdy", srch_rdy, 1);
    check("R3 key", key, {w0, w1, w2, w3});
    check("R4 mpair_hi", mpair_hi, h);
    check("R4 mpair_lo", mpair_lo, l);
    check("R5 addr_top", addr_top, a);
    check("R5 rslt_sel", rslt_sel, r);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [287:0] held;
    cmd_vld = 1'b1; cmd = 11'h006; dq = '1;
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset outputs", {key, mpair_hi, mpair_lo, rslt_sel, addr_top, srch_rdy, proto_err}, '0);
    rst_n = 1'b1;
    beat(1'b0, 11'h000, '0);

    // R1 R2 R7 R8 R9 R11 sequence table
    for (int i = 0; i < NV; i++) begin
      beat(VEC[i][21], VEC[i][20:10], {9{VEC[i][9:2]}});
      check($sformatf("R1 R2 R7 R8 R9 R11 rdy vec %0d", i), srch_rdy, VEC[i][1]);
      check($sformatf("R1 R2 R7 R8 R9 R11 err vec %0d", i), proto_err, VEC[i][0]);
    end

    // R3 R4 R5 with distinct words, ignored bits zero then all ones (R6)
    full_search(72'hA1A2A3A4A5A6A7A8A9, 72'hB1B2B3B4B5B6B7B8B9, 72'hC1C2C3C4C5C6C7C8C9,
                72'hD1D2D3D4D5D6D7D8D9, 4'h9, 4'h6, 3'd5, 3'd2, 9'h000);
    full_search(72'hA1A2A3A4A5A6A7A8A9, 72'hB1B2B3B4B5B6B7B8B9, 72'hC1C2C3C4C5C6C7C8C9,
                72'hD1D2D3D4D5D6D7D8D9, 4'h9, 4'h6, 3'd5, 3'd2, 9'h1FF);
    full_search(72'h0, 72'hFFFFFFFFFFFFFFFFFF, 72'h123456789ABCDEF012, 72'h1,
                4'hF, 4'h0, 3'd7, 3'd0, 9'h0A5);

    // R7 hold while idle and stray cycles
    held = key;
    beat(1'b0, 11'h7FF, '1);
    beat(1'b1, 11'h7F9, '1);
    beat(1'b0, 11'h000, '0);
    check("R7 rdy low after pulse", srch_rdy, 0);
    check("R7 key held", key, held);
    check("R7 fields held", {mpair_hi, mpair_lo, addr_top, rslt_sel}, {4'hF, 4'h0, 3'd7, 3'd0});

    // R9 restart: third beat with flag set becomes new first beat
    beat(1'b1, cmd_a(4'h1, 4'h0), 72'h111111111111111111);
    beat(1'b1, 11'h002, 72'h222222222222222222);
    beat(1'b1, cmd_a(4'hC, 4'h0), 72'hCCCCCCCCCCCCCCCCCC);
    check("R9 restart err", proto_err, 1);
    beat(1'b1, 11'h002, 72'h333333333333333333);
    beat(1'b1, cmd_c(4'h3, 3'd4, 1'b0, 1'b0), 72'h444444444444444444);
    beat(1'b1, cmd_d(3'd6, 6'h0), 72'h555555555555555555);
    check("R9 rdy", srch_rdy, 1);
    check("R9 key", key, {72'hCCCCCCCCCCCCCCCCCC, 72'h333333333333333333,
                           72'h444444444444444444, 72'h555555555555555555});
    check("R9 mpair_hi", mpair_hi, 4'hC);

    // R8 abort after third beat, then idle ignores stray beat (R2)
    beat(1'b1, cmd_a(4'h2, 4'h0), 72'h1);
    beat(1'b1, 11'h002, 72'h2);
    beat(1'b1, cmd_c(4'h2, 3'd1, 1'b0, 1'b0), 72'h3);
    beat(1'b1, 11'h001, 72'h4);
    check("R8 abort err", proto_err, 1);
    check("R8 no rdy", srch_rdy, 0);
    beat(1'b1, 11'h002, 72'h5);
    check("R2 stray err", proto_err, 0);
    check("R2 stray rdy", srch_rdy, 0);
    check("R8 key unchanged", key, {72'hCCCCCCCCCCCCCCCCCC, 72'h333333333333333333,
                                     72'h444444444444444444, 72'h555555555555555555});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule